// File: doc/BRIEF.md
# Dual-Path Transmit Start Controller

This block sits between a MAC and the line-side transmitter. It takes outgoing Ethernet frames one byte at a time and decides when the first byte may go out. A frame can arrive over one of two host paths. A flag that travels with the data says which path delivered it.

A frame from the fast host path is cut through. Output begins once a small, parameterised number of bytes (eight by default) is in the buffer. A frame from the slow management path is stored and forwarded. Nothing leaves until the frame's final byte has been taken in. The start decision uses only the path flag and the byte count. No link speed setting enters into it. The sender is assumed to keep pace once output has begun, so there is no underrun recovery.

Only one frame is handled at a time. The buffer must be at least as deep as the longest frame sent over the slow path (1522 bytes for a tagged maximum frame). The default depth is 2048.

Top module: `txstart_ctrl`

## Requirements
- R1: For a fast-path frame (`in_slow` = 0) of at least START_BYTES bytes, `out_valid` stays low until the START_BYTES-th byte has been accepted. It rises in the cycle right after that acceptance, while output is stalled, whether or not the rest of the frame has arrived.
- R2: For a fast-path frame shorter than START_BYTES, output begins in the cycle after its last byte (`in_last` = 1) is accepted.
- R3: For a slow-path frame (`in_slow` = 1), `out_valid` stays low until the frame's last byte has been accepted. It rises in the following cycle.
- R4: `in_slow` is taken only with the first byte of a frame. Changing it on later bytes of the same frame has no effect on when output starts.
- R5: Output bytes leave in the order they were accepted, with unchanged values. `out_last` is 1 on exactly the final byte of the frame.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R7: `in_ready` is low from the cycle after a frame's last byte is accepted until that frame's last byte is taken at the output. It is high again in the following cycle.
- R8: `in_ready` is low while the buffer holds DEPTH bytes. It returns high once a byte has left.
- R9: After reset, including a reset in the middle of a frame, `out_valid` is 0 and `in_ready` is 1, and any partly received frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DW | Incoming frame byte |
| in_valid | input | 1 | `in_data` is valid |
| in_last | input | 1 | Final byte of the frame |
| in_slow | input | 1 | 1 = slow management path, 0 = fast host path; taken with the first byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_data | output | DW | Outgoing byte |
| out_valid | output | 1 | `out_data` is valid |
| out_last | output | 1 | Final byte of the frame |
| out_ready | input | 1 | Line side takes the byte this cycle |

## Verification
The bench builds the block with DEPTH = 16 and START_BYTES = 8, keeping the default byte width. The small depth means a fast frame of 40 bytes with a held-off output can actually fill the buffer, which brings the full-buffer back-pressure of R8 within reach. A 16-byte slow frame fills the buffer exactly at its last byte. Frames of 1, 5, 8 and 9 bytes sit on both sides of the cut-through threshold. Changing the path flag after the first byte and stalling the output with rotating patterns exercise R4 and R6.

// File: rtl/txstart_ctrl.sv
module txstart_ctrl #(
  parameter int DW          = 8,
  parameter int DEPTH       = 2048,
  parameter int START_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          in_slow,
  output logic          in_ready,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_last,
  input  logic          out_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);
  localparam int CW = $clog2(START_BYTES + 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [FW-1:0] FULL_FILL = FW'(DEPTH);
  localparam logic [CW-1:0] START_CNT = CW'(START_BYTES);

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [FW-1:0] fill;
  logic [CW-1:0] seen;
  logic          slow_q, got_last;
  logic          wr, rd, done, launch;

  assign in_ready  = !got_last && (fill != FULL_FILL);
  assign wr        = in_valid && in_ready;
  assign launch    = got_last || (!slow_q && seen == START_CNT);
  assign out_valid = launch && (fill != '0);
  assign out_data  = mem[rp][DW-1:0];
  assign out_last  = mem[rp][DW];
  assign rd        = out_valid && out_ready;
  assign done      = rd && out_last;

  always_ff @(posedge clk)
    if (wr) mem[wp] <= {in_last, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      fill     <= '0;
      seen     <= '0;
      slow_q   <= 1'b0;
      got_last <= 1'b0;
    end else begin
      if (wr) wp <= (wp == LAST_ADDR) ? '0 : wp + 1'b1;
      if (rd) rp <= (rp == LAST_ADDR) ? '0 : rp + 1'b1;
      fill <= fill + FW'(wr) - FW'(rd);
      if (wr && seen == '0) slow_q <= in_slow;
      if (done)                          seen <= '0;
      else if (wr && seen != START_CNT)  seen <= seen + 1'b1;
      if (done)               got_last <= 1'b0;
      else if (wr && in_last) got_last <= 1'b1;
    end
  end

  assert_slow_whole_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && slow_q) |-> got_last);

  assert_fast_thresh_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !got_last) |-> (!slow_q && seen == START_CNT));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_FILL);

  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_one_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    got_last |-> !in_ready);

  assert_path_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen != '0) |=> $stable(slow_q));
endmodule

// File: tb/txstart_ctrl_tb_top.sv
module txstart_ctrl_tb_top;
  localparam int DEPTH = 16;
  localparam int START = 8;
  localparam int NV    = 13;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] in_data, out_data;
  logic       in_valid, in_last, in_slow, in_ready;
  logic       out_valid, out_last, out_ready;
  int compared = 0, mismatched = 0;

  always #2 clk = ~clk;

  txstart_ctrl #(.DW(8), .DEPTH(DEPTH), .START_BYTES(START)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_slow(in_slow), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .out_ready(out_ready));

  // {slow, flip, len[16], hold[8], stall mask[4], seed[8]}
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'd12, 8'd0,  4'h0, 8'h10},
    {1'b1, 1'b0, 16'd12, 8'd0,  4'h0, 8'h20},
    {1'b0, 1'b0, 16'd5,  8'd0,  4'h0, 8'h30},
    {1'b0, 1'b0, 16'd8,  8'd0,  4'h0, 8'h40},
    {1'b0, 1'b0, 16'd9,  8'd0,  4'h0, 8'h50},
    {1'b1, 1'b0, 16'd1,  8'd0,  4'h0, 8'h60},
    {1'b0, 1'b0, 16'd1,  8'd0,  4'h0, 8'h70},
    {1'b1, 1'b0, 16'd16, 8'd0,  4'h0, 8'h80},
    {1'b0, 1'b0, 16'd40, 8'd30, 4'h0, 8'h90},
    {1'b0, 1'b1, 16'd20, 8'd0,  4'h0, 8'hA0},
    {1'b1, 1'b1, 16'd10, 8'd0,  4'h0, 8'hB0},
    {1'b0, 1'b0, 16'd24, 8'd0,  4'h5, 8'hC0},
    {1'b1, 1'b0, 16'd16, 8'd0,  4'h3, 8'hD0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input bit slow, input bit flip, input int len,
                           input int hold, input logic [3:0] mask, input logic [7:0] seed);
    int n_in = 0, n_out = 0, cyc = 0;
    int first = slow ? len : ((len < START) ? len : START);
    bit started, exp_rdy, exp_vld, was_stall = 0;
    logic [7:0] pd = '0;
    logic pl = 1'b0;
    string sreq;
    sreq = flip ? "R4" : (slow ? "R3" : ((len < START) ? "R2" : "R1"));
    while (n_out < len && cyc < 4000) begin
      @(negedge clk);
      in_valid  = (n_in < len);
      in_data   = 8'(seed + n_in);
      in_last   = (n_in == len - 1);
      in_slow   = (flip && n_in > 0) ? !slow : slow;
      out_ready = (cyc >= hold) && !mask[cyc % 4];
      #1;
      started = slow ? (n_in == len) : (n_in >= first);
      exp_rdy = (n_in < len) && (n_in - n_out < DEPTH);
      exp_vld = started && (n_in > n_out);
      chk(in_ready == exp_rdy, (n_in - n_out == DEPTH) ? "R8" : "R7", in_ready, exp_rdy);
      chk(out_valid == exp_vld, sreq, out_valid, exp_vld);
      if (was_stall) begin
        chk(out_valid && out_data == pd, "R6 data", out_data, pd);
        chk(out_last == pl, "R6 last", out_last, pl);
      end
      was_stall = out_valid && !out_ready;
      pd = out_data;
      pl = out_last;
      if (out_valid && out_ready) begin
        chk(out_data == 8'(seed + n_out), "R5 data", out_data, 8'(seed + n_out));
        chk(out_last == (n_out == len - 1), "R5 last", out_last, (n_out == len - 1));
        n_out++;
      end
      if (in_valid && in_ready) n_in++;
      cyc++;
    end
    chk(n_out == len, "R5 count", n_out, len);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; in_data = '0; in_last = 0; in_slow = 0; out_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset valid", out_valid, 0);
    chk(in_ready == 1'b1, "R9 reset ready", in_ready, 1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run_frame(VEC[i][37], VEC[i][36], int'(VEC[i][35:20]), int'(VEC[i][19:12]),
                VEC[i][11:8], VEC[i][7:0]);

    // R9: reset in the middle of a fast frame
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      in_valid = 1; in_data = 8'(k); in_last = 0; in_slow = 0; out_ready = 0;
    end
    @(negedge clk);
    in_valid = 0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R9 midframe valid", out_valid, 0);
    chk(in_ready == 1'b1, "R9 midframe ready", in_ready, 1);
    run_frame(1'b0, 1'b0, 11, 0, 4'h2, 8'hE0);
    run_frame(1'b1, 1'b0, 3, 2, 4'h0, 8'hF0);

    @(negedge clk);
    in_valid = 0; out_ready = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule